// File: doc/BRIEF.md
# Memory Operand Address Generator

This block forms the effective address of one memory operand for a CISC-style core whose ordinary instructions can reach memory directly. A decode stage gives it an addressing-mode code, the base and index register values, the current program counter, a 32-bit immediate, an access-size code, a 32/64-bit operating flag and the base of the thread-local data segment. One cycle later the block returns the address. For modes that move a pointer, it also returns an update strobe and the new base value.

The modes cover the following:
- base plus displacement;
- base plus displacement plus an index scaled by the access size;
- the same two forms built on the program counter;
- a zero-extended 32-bit absolute address;
- a thread-local absolute offset added to the segment base;
- pre/post increment and decrement, with either a unit stride or a signed immediate stride.

The path is purely combinational, followed by one output register stage.

Top module: `agu_top`

## Requirements
- R1: Mode code 0 (base+disp) gives address = base + sign-extended imm.
- R2: Mode codes 1 (base+index) and 3 (pc+index) add imm and index × access bytes to base or pc, respectively. Size code 0..4 means 1, 2, 4, 8 or 16 bytes, and codes 5..7 act as 16 bytes.
- R3: Mode code 2 (pc-relative) gives address = pc + sign-extended imm, in both 32-bit and 64-bit operation.
- R4: Mode code 4 (absolute) gives address = imm zero-extended, so the bits above bit 31 are always zero.
- R5: Mode code 9 (thread-local absolute) gives address = segment base + zero-extended imm.
- R6: Mode codes 5 (pre-increment) and 6 (pre-decrement) give address = base + stride and base − stride, respectively. The write-back value equals that address.
- R7: Mode codes 7 (post-increment) and 8 (post-decrement) give address = unmodified base. The write-back value is base + stride or base − stride, respectively.
- R8: The stride is the access size in bytes when unit_stride_i is 1, and the sign-extended imm when it is 0.
- R9: When mode64_i is 0, the address and the write-back value keep only their low 32 bits, and the upper bits are zero.
- R10: wb_en_o is 1 only for a valid operation with mode codes 5..8. Undefined codes 10..15 give address 0, write-back value 0 and no update.
- R11: valid_o follows valid_i by exactly one clock. After reset, valid_o, wb_en_o, addr_o and wb_val_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand request valid |
| mode_i | input | 4 | Addressing-mode code |
| size_i | input | 3 | Access-size code (bytes = 1 << min(code,4)) |
| unit_stride_i | input | 1 | 1: stride = access size, 0: stride = imm |
| mode64_i | input | 1 | 1: 64-bit operation, 0: 32-bit truncation |
| base_i | input | XLEN | Base register value |
| index_i | input | XLEN | Index register value |
| pc_i | input | XLEN | Current program counter |
| imm_i | input | 32 | Displacement, stride or absolute address |
| seg_base_i | input | XLEN | Thread-local segment base |
| valid_o | output | 1 | Result valid |
| addr_o | output | XLEN | Effective address |
| wb_en_o | output | 1 | Base register update strobe |
| wb_val_o | output | XLEN | Updated base value |

## Verification
The hardest situation to reach from the ports is a carry or borrow that crosses bit 31 in 32-bit operation. There the truncated result differs from the full sum only when the operands sit at the 4 GB boundary. A second such situation is a negative immediate stride on a post-decrement, which has to move the pointer upward.

The stimulus sweeps every mode code, size code, stride selection and operating width over operand sets chosen for these cases:
- bases just below 2^32;
- indices with high bits set;
- immediates of 0x7FFFFFFF and 0x80000000.

This means every wrap, sign extension and clamp of the size code is met under each mode.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int MODE_W = 4;
  localparam int SIZE_W = 3;
  localparam int IMM_W  = 32;
  localparam int MAX_SHIFT = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_BDISP   = 4'd0,
    AM_BIDX    = 4'd1,
    AM_PCREL   = 4'd2,
    AM_PCIDX   = 4'd3,
    AM_ABS     = 4'd4,
    AM_PREINC  = 4'd5,
    AM_PREDEC  = 4'd6,
    AM_POSTINC = 4'd7,
    AM_POSTDEC = 4'd8,
    AM_TLSABS  = 4'd9
  } amode_e;

  function automatic logic is_modify(logic [MODE_W-1:0] m);
    return (m >= AM_PREINC) && (m <= AM_POSTDEC);
  endfunction
endpackage

// File: rtl/agu_scale.sv
module agu_scale
  import agu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic [XLEN-1:0]   index_i,
  output logic [XLEN-1:0]   bytes_o,
  output logic [XLEN-1:0]   scaled_o
);
  logic [2:0] shamt;

  // size codes above the largest access clamp to 16 bytes
  assign shamt    = (size_i > SIZE_W'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : size_i;
  assign bytes_o  = XLEN'(1) << shamt;
  assign scaled_o = index_i << shamt;
endmodule

// File: rtl/agu_calc.sv
module agu_calc
  import agu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              unit_stride_i,
  input  logic              mode64_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   seg_base_i,
  input  logic [XLEN-1:0]   bytes_i,
  input  logic [XLEN-1:0]   scaled_i,
  output logic [XLEN-1:0]   addr_o,
  output logic [XLEN-1:0]   wb_val_o,
  output logic              wb_en_o
);
  localparam logic [XLEN-1:0] LO_MASK = {{(XLEN-IMM_W){1'b0}}, {IMM_W{1'b1}}};

  logic [XLEN-1:0] imm_sx, imm_zx, stride, inc, dec;
  logic [XLEN-1:0] addr_raw, wb_raw;

  assign imm_sx = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign imm_zx = {{(XLEN-IMM_W){1'b0}}, imm_i};
  assign stride = unit_stride_i ? bytes_i : imm_sx;
  assign inc    = base_i + stride;
  assign dec    = base_i - stride;

  always_comb begin
    addr_raw = '0;
    wb_raw   = '0;
    case (mode_i)
      AM_BDISP:   addr_raw = base_i + imm_sx;
      AM_BIDX:    addr_raw = base_i + imm_sx + scaled_i;
      AM_PCREL:   addr_raw = pc_i + imm_sx;
      AM_PCIDX:   addr_raw = pc_i + imm_sx + scaled_i;
      AM_ABS:     addr_raw = imm_zx;
      AM_TLSABS:  addr_raw = seg_base_i + imm_zx;
      AM_PREINC:  begin addr_raw = inc;    wb_raw = inc; end
      AM_PREDEC:  begin addr_raw = dec;    wb_raw = dec; end
      AM_POSTINC: begin addr_raw = base_i; wb_raw = inc; end
      AM_POSTDEC: begin addr_raw = base_i; wb_raw = dec; end
      default:    ;
    endcase
  end

  assign addr_o   = mode64_i ? addr_raw : (addr_raw & LO_MASK);
  assign wb_val_o = mode64_i ? wb_raw   : (wb_raw & LO_MASK);
  assign wb_en_o  = is_modify(mode_i);
endmodule

// File: rtl/agu_out_reg.sv
module agu_out_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic            wb_en_i,
  input  logic [XLEN-1:0] wb_val_i,
  output logic            valid_o,
  output logic [XLEN-1:0] addr_o,
  output logic            wb_en_o,
  output logic [XLEN-1:0] wb_val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      wb_en_o  <= 1'b0;
      wb_val_o <= '0;
    end else begin
      valid_o <= valid_i;
      wb_en_o <= valid_i & wb_en_i;
      if (valid_i) begin
        addr_o   <= addr_i;
        wb_val_o <= wb_val_i;
      end
    end
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              unit_stride_i,
  input  logic              mode64_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   index_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   seg_base_i,
  output logic              valid_o,
  output logic [XLEN-1:0]   addr_o,
  output logic              wb_en_o,
  output logic [XLEN-1:0]   wb_val_o
);
  logic [XLEN-1:0] bytes, scaled, addr_c, wb_c;
  logic            wb_en_c;

  agu_scale #(.XLEN(XLEN)) u_scale (
    .size_i  (size_i),
    .index_i (index_i),
    .bytes_o (bytes),
    .scaled_o(scaled)
  );

  agu_calc #(.XLEN(XLEN)) u_calc (
    .mode_i       (mode_i),
    .unit_stride_i(unit_stride_i),
    .mode64_i     (mode64_i),
    .base_i       (base_i),
    .pc_i         (pc_i),
    .imm_i        (imm_i),
    .seg_base_i   (seg_base_i),
    .bytes_i      (bytes),
    .scaled_i     (scaled),
    .addr_o       (addr_c),
    .wb_val_o     (wb_c),
    .wb_en_o      (wb_en_c)
  );

  agu_out_reg #(.XLEN(XLEN)) u_oreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .addr_i  (addr_c),
    .wb_en_i (wb_en_c),
    .wb_val_i(wb_c),
    .valid_o (valid_o),
    .addr_o  (addr_o),
    .wb_en_o (wb_en_o),
    .wb_val_o(wb_val_o)
  );

  // R11
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R11
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R10
  wb_en_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> valid_o);
  // R10
  no_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_modify(mode_i)) |=> !wb_en_o);
  // R9
  trunc32_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode64_i) |=> (addr_o[XLEN-1:IMM_W] == '0) && (wb_val_o[XLEN-1:IMM_W] == '0));
  // R7
  post_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode64_i && (mode_i == AM_POSTINC || mode_i == AM_POSTDEC))
      |=> addr_o == $past(base_i));
  // R4
  abs_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == AM_ABS) |=> addr_o[XLEN-1:IMM_W] == '0);
endmodule

// File: tb/sim_agu_top.sv
module sim_agu_top;
  localparam int XLEN = 64;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0;
  logic [3:0]      mode = '0;
  logic [2:0]      size = '0;
  logic            unit = 1'b0;
  logic            m64 = 1'b1;
  logic [XLEN-1:0] base = '0, index = '0, pc = '0, seg = '0;
  logic [31:0]     imm = '0;
  logic            valid_o, wb_en_o;
  logic [XLEN-1:0] addr_o, wb_val_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agu_top #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode), .size_i(size),
    .unit_stride_i(unit), .mode64_i(m64), .base_i(base), .index_i(index),
    .pc_i(pc), .imm_i(imm), .seg_base_i(seg),
    .valid_o(valid_o), .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_val_o(wb_val_o)
  );

  function automatic string tag_of(int m);
    case (m)
      0: return "R1";
      1, 3: return "R2";
      2: return "R3";
      4: return "R4";
      9: return "R5";
      5, 6: return "R6";
      7, 8: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mode=%0d size=%0d unit=%0d m64=%0d act=%h exp=%h",
               tag, mode, size, unit, m64, act, exp);
    end
  endtask

  logic [XLEN-1:0] b_set[4] = '{64'h0000_0000_0000_1000, 64'h0000_0000_FFFF_FFF8,
                                64'h8000_0001_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0};
  logic [XLEN-1:0] x_set[4] = '{64'h3, 64'h0000_0000_1000_0001,
                                64'hF000_0000_0000_0002, 64'hFFFF_FFFF_FFFF_FFFF};
  logic [XLEN-1:0] p_set[4] = '{64'h0000_0000_0040_0000, 64'h0000_0000_FFFF_FF00,
                                64'h0000_7FFF_0000_0000, 64'h1};
  logic [31:0]     i_set[4] = '{32'h0000_0010, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFC};
  logic [XLEN-1:0] s_set[4] = '{64'h0000_7F00_0000_0000, 64'h0000_0000_F000_0000,
                                64'h0, 64'hFFFF_FFFF_0000_0000};

  initial begin
    logic [XLEN-1:0] sx, zx, nb, sc, st, ea, wb, msk;
    logic            en;
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11", {63'b0, valid_o}, 64'h0);
    check("R11", {63'b0, wb_en_o}, 64'h0);
    check("R11", addr_o, 64'h0);
    check("R11", wb_val_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 4; s++)
      for (int md = 0; md < 16; md++)
        for (int sz = 0; sz < 8; sz++)
          for (int u = 0; u < 2; u++)
            for (int w = 0; w < 2; w++) begin
              valid = 1'b1; mode = 4'(md); size = 3'(sz); unit = u[0]; m64 = w[0];
              base = b_set[s]; index = x_set[s]; pc = p_set[s]; imm = i_set[s]; seg = s_set[s];
              sx = {{32{imm[31]}}, imm};
              zx = {32'h0, imm};
              nb = 64'd1 << ((sz > 4) ? 4 : sz);
              sc = index * nb;
              st = u ? nb : sx;   // R8
              ea = '0; wb = '0; en = 1'b0;
              case (md)
                0: ea = base + sx;
                1: ea = base + sx + sc;
                2: ea = pc + sx;
                3: ea = pc + sx + sc;
                4: ea = zx;
                9: ea = seg + zx;
                5: begin ea = base + st; wb = ea; en = 1'b1; end
                6: begin ea = base - st; wb = ea; en = 1'b1; end
                7: begin ea = base; wb = base + st; en = 1'b1; end
                8: begin ea = base; wb = base - st; en = 1'b1; end
                default: ;
              endcase
              msk = w ? '1 : 64'h0000_0000_FFFF_FFFF;  // R9
              ea &= msk; wb &= msk;
              @(posedge clk); #1;
              check({tag_of(md), "/R8/R9"}, addr_o, ea);
              check({tag_of(md), "/R10"}, {63'b0, wb_en_o}, {63'b0, en});
              if (en) check({tag_of(md), "/R8/R9"}, wb_val_o, wb);
              check("R11", {63'b0, valid_o}, 64'h1);
              @(negedge clk);
            end
    // R11 / R10: idle cycle drops valid and update strobe
    valid = 1'b0; mode = 4'd5;
    @(posedge clk); #1;
    check("R11", {63'b0, valid_o}, 64'h0);
    check("R10", {63'b0, wb_en_o}, 64'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog R11 act=hung exp=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule